// File: doc/BRIEF.md
# Double-Buffered Synthesizer Control Register Bank

This block holds the divider ratios and mode bits for two synthesizer loops, a main loop and an auxiliary loop, and presents them to the loop hardware as stable parallel words. A host writes it one byte at a time. Each multi-byte register has two stages. Ordinary byte writes only fill a staging copy. A write to the register's least significant byte then moves the whole staged word into the active copy in one clock, so the divider never sees half of an old ratio mixed with half of a new one.

Each loop's enable bit is not a plain buffered bit. It behaves like a set/reset latch. It is set only when a commit carries a staged enable of 1. It is cleared as soon as the top byte of the loop's M register is written with enable 0, with no low-byte write needed. To wake a loop, the host writes the top byte with enable 1 and then the low byte. The enable and the new ratio then arrive together.

The external lock-detect inputs may be asynchronous, so each one is resynchronised. It is gated with that loop's enable to form a lock flag. The lock flags drive a status word and a maskable, sticky interrupt request.

Top module: `pll_ctl_regs`

## Requirements
- R1: The write port never applies back-pressure. `host_ready` is 1 in every cycle, including reset, and every cycle with `host_valid` high is one accepted byte write.
- R2: A write to a byte other than a register's least significant byte changes no active output. Byte offsets from base 0x20 are: main M at 0x20 (top) and 0x21 (low); main N at 0x22, 0x23 and 0x24 (low); aux M at 0x25 and 0x26 (low); aux N at 0x27 and 0x28 (low). The lowest address of each register is its most significant byte.
- R3: A write to a register's least significant byte loads all of its staged bytes plus the new low byte into the active outputs, visible from the next clock. The active words are: `main_m` = {0x20[5:0], 0x21}; `main_n` = {0x22[3:0], 0x23, 0x24}; `aux_m` = {0x25[4:0], 0x26}; `aux_n` = {0x27[5:0], 0x28}.
- R4: An enable (`main_en` from 0x20 bit 7, `aux_en` from 0x25 bit 7) rises only in the clock after a low-byte write to that loop's M register while the staged bit 7 is 1. Writing the top byte with bit 7 = 1 alone leaves the enable at 0.
- R5: Writing 0x20 (or 0x25) with bit 7 = 0 drops `main_en` (or `aux_en`) from the next clock, without a low-byte write. The active divider words are unchanged.
- R6: The mode bits update only on the commit of their own register. The bits are: `main_lo_div1` = 0x20 bit 6 (1 = divide by 1, 0 = divide by 2); `main_sign` = 0x22 bit 7 (0 = add, 1 = subtract); `aux_if_flt` = 0x25 bits 6:5 (00/01/10/11 = 90/80/45/40 MHz); `aux_if_div2` = 0x27 bit 7 (0 = divide by 1, 1 = divide by 2).
- R7: `main_lock` and `aux_lock` are 1 only while their loop is enabled and the lock input, delayed by two clock stages, is 1. A lock input change is visible after the second rising edge. `stat_flags` = {aux_lock, main_lock}.
- R8: A change of a lock flag whose `irq_mask` bit is set (bit 0 main, bit 1 aux) makes `irq` 1 from the following clock. `irq` stays 1 until a cycle with `stat_rd` high. If a new masked change coincides with the read, it wins.
- R9: Writes to addresses outside 0x20 to 0x28 change no output.
- R10: After reset all staged and active bytes, both enables, the lock flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Byte write request |
| host_ready | output | 1 | Always 1 |
| host_addr | input | 8 | Byte address |
| host_data | input | 8 | Byte data |
| lock_det_main | input | 1 | Main loop lock detect, asynchronous |
| lock_det_aux | input | 1 | Aux loop lock detect, asynchronous |
| irq_mask | input | 2 | Interrupt enable per flag |
| stat_rd | input | 1 | Status read strobe, clears pending interrupt |
| stat_flags | output | 2 | {aux_lock, main_lock} |
| irq | output | 1 | Interrupt request |
| main_en | output | 1 | Main loop enable |
| main_m | output | 14 | Main M divider |
| main_lo_div1 | output | 1 | Main LO divide select |
| main_n | output | 20 | Main N divider |
| main_sign | output | 1 | IF summer polarity |
| aux_en | output | 1 | Aux loop enable |
| aux_m | output | 13 | Aux M divider |
| aux_if_flt | output | 2 | IF filter code |
| aux_n | output | 14 | Aux N divider |
| aux_if_div2 | output | 1 | Aux IF divide select |
| main_lock | output | 1 | Main loop locked and enabled |
| aux_lock | output | 1 | Aux loop locked and enabled |

## Verification
The assertions assume that `host_valid`, `host_addr`, `host_data`, `stat_rd` and `irq_mask` are driven clean and stable around each rising edge. Only the two lock-detect inputs are allowed to move freely. The stimulus changes every input on the falling edge. It toggles the lock inputs at arbitrary falling edges, including while an enable is changing. It issues top-byte writes with and without a following low-byte write, so that the enable and commit rules are exercised only through legal byte writes.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  localparam int REG_BYTES   = 9;
  localparam int MM_OFS      = 0;
  localparam int MM_NB       = 2;
  localparam int MN_OFS      = 2;
  localparam int MN_NB       = 3;
  localparam int AM_OFS      = 5;
  localparam int AM_NB       = 2;
  localparam int AN_OFS      = 7;
  localparam int AN_NB       = 2;
  localparam int MM_W        = 14;
  localparam int MN_W        = 20;
  localparam int AM_W        = 13;
  localparam int AN_W        = 14;
  localparam int EN_BIT      = 7;
  localparam int LOCK_CH     = 2;
endpackage

// File: rtl/pll_stage_reg.sv
module pll_stage_reg #(
  parameter int NB  = 2,
  parameter int OFS = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_idx,
  input  logic [7:0]      wr_data,
  output logic [8*NB-1:0] stg_o,
  output logic [8*NB-1:0] act_o,
  output logic            commit_o
);
  localparam int W       = 8 * NB;
  localparam int LOW_IDX = OFS + NB - 1;

  logic [W-1:0] stg_q;
  logic [W-1:0] act_q;
  logic         hit_low;

  assign hit_low = wr_en && (wr_idx == 8'(LOW_IDX));

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        stg_q[W-1-8*b -: 8] <= '0;
      else if (wr_en && (wr_idx == 8'(OFS + b)))
        stg_q[W-1-8*b -: 8] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      act_q <= '0;
    else if (hit_low)
      act_q <= {stg_q[W-1:8], wr_data};
  end

  assign stg_o    = stg_q;
  assign act_o    = act_q;
  assign commit_o = hit_low;
endmodule

// File: rtl/pll_en_latch.sv
module pll_en_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (clr_i) q <= 1'b0;
    else if (set_i) q <= 1'b1;
  end
  assign q_o = q;
endmodule

// File: rtl/pll_lock_mon.sv
module pll_lock_mon #(
  parameter int CH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] det_i,
  input  logic [CH-1:0] en_i,
  output logic [CH-1:0] lock_o
);
  logic [CH-1:0] s1_q, s2_q;
  for (genvar c = 0; c < CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1_q[c] <= 1'b0;
        s2_q[c] <= 1'b0;
      end else begin
        s1_q[c] <= det_i[c];
        s2_q[c] <= s1_q[c];
      end
    end
    assign lock_o[c] = en_i[c] & s2_q[c];
  end
endmodule

// File: rtl/pll_irq_ctl.sv
module pll_irq_ctl #(
  parameter int CH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] flag_i,
  input  logic [CH-1:0] mask_i,
  input  logic          rd_i,
  output logic          irq_o
);
  logic [CH-1:0] prev_q, pend_q, pend_d;

  always_comb begin
    pend_d = rd_i ? '0 : pend_q;
    pend_d = pend_d | ((flag_i ^ prev_q) & mask_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= flag_i;
      pend_q <= pend_d;
    end
  end

  assign irq_o = |pend_q;
endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
  import pll_ctl_pkg::*;
#(
  parameter logic [7:0] BASE = 8'h20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_valid,
  output logic                 host_ready,
  input  logic [7:0]           host_addr,
  input  logic [7:0]           host_data,
  input  logic                 lock_det_main,
  input  logic                 lock_det_aux,
  input  logic [LOCK_CH-1:0]   irq_mask,
  input  logic                 stat_rd,
  output logic [LOCK_CH-1:0]   stat_flags,
  output logic                 irq,
  output logic                 main_en,
  output logic [MM_W-1:0]      main_m,
  output logic                 main_lo_div1,
  output logic [MN_W-1:0]      main_n,
  output logic                 main_sign,
  output logic                 aux_en,
  output logic [AM_W-1:0]      aux_m,
  output logic [1:0]           aux_if_flt,
  output logic [AN_W-1:0]      aux_n,
  output logic                 aux_if_div2,
  output logic                 main_lock,
  output logic                 aux_lock
);
  logic [7:0] widx;
  logic       in_map, wr_en;

  assign widx       = host_addr - BASE;
  assign in_map     = (host_addr >= BASE) && (widx < 8'(REG_BYTES));
  assign wr_en      = host_valid && in_map;
  assign host_ready = 1'b1;

  logic [8*MM_NB-1:0] mm_stg, mm_act;
  logic [8*MN_NB-1:0] mn_stg, mn_act;
  logic [8*AM_NB-1:0] am_stg, am_act;
  logic [8*AN_NB-1:0] an_stg, an_act;
  logic mm_cmt, mn_cmt, am_cmt, an_cmt;

  pll_stage_reg #(.NB(MM_NB), .OFS(MM_OFS)) u_mm (
    .clk, .rst_n, .wr_en, .wr_idx(widx), .wr_data(host_data),
    .stg_o(mm_stg), .act_o(mm_act), .commit_o(mm_cmt));
  pll_stage_reg #(.NB(MN_NB), .OFS(MN_OFS)) u_mn (
    .clk, .rst_n, .wr_en, .wr_idx(widx), .wr_data(host_data),
    .stg_o(mn_stg), .act_o(mn_act), .commit_o(mn_cmt));
  pll_stage_reg #(.NB(AM_NB), .OFS(AM_OFS)) u_am (
    .clk, .rst_n, .wr_en, .wr_idx(widx), .wr_data(host_data),
    .stg_o(am_stg), .act_o(am_act), .commit_o(am_cmt));
  pll_stage_reg #(.NB(AN_NB), .OFS(AN_OFS)) u_an (
    .clk, .rst_n, .wr_en, .wr_idx(widx), .wr_data(host_data),
    .stg_o(an_stg), .act_o(an_act), .commit_o(an_cmt));

  // Enable: set by a commit carrying enable, cleared by a top-byte write without it.
  logic m_set, m_clr, a_set, a_clr;
  assign m_set = mm_cmt && mm_stg[8*MM_NB-1-(7-EN_BIT)];
  assign m_clr = wr_en && (widx == 8'(MM_OFS)) && !host_data[EN_BIT];
  assign a_set = am_cmt && am_stg[8*AM_NB-1-(7-EN_BIT)];
  assign a_clr = wr_en && (widx == 8'(AM_OFS)) && !host_data[EN_BIT];

  pll_en_latch u_men (.clk, .rst_n, .set_i(m_set), .clr_i(m_clr), .q_o(main_en));
  pll_en_latch u_aen (.clk, .rst_n, .set_i(a_set), .clr_i(a_clr), .q_o(aux_en));

  assign main_m       = mm_act[MM_W-1:0];
  assign main_lo_div1 = mm_act[14];
  assign main_n       = mn_act[MN_W-1:0];
  assign main_sign    = mn_act[23];
  assign aux_m        = am_act[AM_W-1:0];
  assign aux_if_flt   = am_act[14:13];
  assign aux_n        = an_act[AN_W-1:0];
  assign aux_if_div2  = an_act[15];

  logic [LOCK_CH-1:0] lk;
  pll_lock_mon #(.CH(LOCK_CH)) u_lock (
    .clk, .rst_n,
    .det_i({lock_det_aux, lock_det_main}),
    .en_i({aux_en, main_en}),
    .lock_o(lk));

  assign main_lock  = lk[0];
  assign aux_lock   = lk[1];
  assign stat_flags = lk;

  pll_irq_ctl #(.CH(LOCK_CH)) u_irq (
    .clk, .rst_n, .flag_i(lk), .mask_i(irq_mask), .rd_i(stat_rd), .irq_o(irq));
endmodule

// File: rtl/pll_ctl_regs_chk.sv
module pll_ctl_regs_chk #(
  parameter logic [7:0] BASE = 8'h20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_valid,
  input logic        host_ready,
  input logic [7:0]  host_addr,
  input logic [7:0]  host_data,
  input logic        stat_rd,
  input logic        irq,
  input logic        main_en,
  input logic        aux_en,
  input logic [13:0] main_m,
  input logic [12:0] aux_m,
  input logic        main_lock,
  input logic        aux_lock
);
  // R1
  ready_high_chk: assert property (@(posedge clk) host_ready);

  // R5
  main_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_addr == BASE && !host_data[7]) |=> !main_en);

  // R5
  aux_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_addr == BASE + 8'd5 && !host_data[7]) |=> !aux_en);

  // R4
  main_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_en) |-> $past(host_valid && host_addr == BASE + 8'd1));

  // R4
  aux_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_en) |-> $past(host_valid && host_addr == BASE + 8'd6));

  // R2
  main_m_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_valid && host_addr == BASE + 8'd1) |=> $stable(main_m));

  // R2
  aux_m_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_valid && host_addr == BASE + 8'd6) |=> $stable(aux_m));

  // R7
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_lock |-> main_en) and (aux_lock |-> aux_en));

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_rd) |=> irq);
endmodule

bind pll_ctl_regs pll_ctl_regs_chk #(.BASE(BASE)) u_chk (.*);

// File: tb/pll_ctl_regs_bench.sv
module pll_ctl_regs_bench;
  logic clk = 0, rst_n = 0;
  logic host_valid = 0, host_ready;
  logic [7:0] host_addr = 0, host_data = 0;
  logic lock_det_main = 0, lock_det_aux = 0;
  logic [1:0] irq_mask = 0;
  logic stat_rd = 0;
  logic [1:0] stat_flags;
  logic irq, main_en, main_lo_div1, main_sign, aux_en, aux_if_div2, main_lock, aux_lock;
  logic [13:0] main_m;
  logic [19:0] main_n;
  logic [12:0] aux_m;
  logic [1:0]  aux_if_flt;
  logic [13:0] aux_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pll_ctl_regs u_pll_ctl_regs (.*);

  task automatic chk(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // Behavioural reference model, byte-indexed from base 0x20
  bit [7:0] m_stg [9];
  bit [7:0] m_act [9];
  bit m_men, m_aen;
  bit [1:0] m_s1, m_s2, m_prev, m_pend;

  function automatic bit [1:0] m_flags();
    return {m_aen & m_s2[1], m_men & m_s2[0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_stg[i]) begin m_stg[i] = 0; m_act[i] = 0; end
      m_men = 0; m_aen = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0;
    end else begin
      bit [1:0] f;
      f = m_flags();
      if (stat_rd) m_pend = 0;
      m_pend |= (f ^ m_prev) & irq_mask;
      m_prev = f;
      m_s2 = m_s1;
      m_s1 = {lock_det_aux, lock_det_main};
      if (host_valid && host_addr >= 8'h20 && host_addr <= 8'h28) begin
        int k;
        k = host_addr - 8'h20;
        m_stg[k] = host_data;
        case (k)
          0: if (!host_data[7]) m_men = 0;
          5: if (!host_data[7]) m_aen = 0;
          1: begin for (int j = 0; j <= 1; j++) m_act[j] = m_stg[j]; if (m_stg[0][7]) m_men = 1; end
          4: for (int j = 2; j <= 4; j++) m_act[j] = m_stg[j];
          6: begin for (int j = 5; j <= 6; j++) m_act[j] = m_stg[j]; if (m_stg[5][7]) m_aen = 1; end
          8: for (int j = 7; j <= 8; j++) m_act[j] = m_stg[j];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R1 ready", host_ready, 1);
    chk("R3 main_m", main_m, {m_act[0][5:0], m_act[1]});
    chk("R3 main_n", main_n, {m_act[2][3:0], m_act[3], m_act[4]});
    chk("R3 aux_m", aux_m, {m_act[5][4:0], m_act[6]});
    chk("R3 aux_n", aux_n, {m_act[7][5:0], m_act[8]});
    chk("R6 ctl", {main_lo_div1, main_sign, aux_if_flt, aux_if_div2},
        {m_act[0][6], m_act[2][7], m_act[5][6:5], m_act[7][7]});
    chk("R4 enables", {aux_en, main_en}, {m_aen, m_men});
    chk("R7 flags", {stat_flags, aux_lock, main_lock}, {m_flags(), m_flags()});
    chk("R8 irq", irq, |m_pend);
  end

  task automatic wr(bit [7:0] a, bit [7:0] d);
    host_valid = 1; host_addr = a; host_data = d;
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R10 reset outs", {main_en, aux_en, main_m, main_n, aux_m, aux_n, irq, stat_flags}, 0);
    chk("R1 ready in reset", host_ready, 1);
    rst_n = 1;
    step(1);
    // main M: top byte only
    wr(8'h20, 8'hC1);
    chk("R2 main_m after top byte", main_m, 0);
    chk("R4 no enable before commit", main_en, 0);
    chk("R6 lo div held", main_lo_div1, 0);
    wr(8'h21, 8'h23);
    chk("R3 main_m commit", main_m, 14'h0123);
    chk("R4 enable at commit", main_en, 1);
    chk("R6 lo div commit", main_lo_div1, 1);
    // main N
    wr(8'h22, 8'h85); wr(8'h23, 8'h67);
    chk("R2 main_n staged only", main_n, 0);
    chk("R6 sign held", main_sign, 0);
    wr(8'h24, 8'h89);
    chk("R3 main_n commit", main_n, 20'h56789);
    chk("R6 sign commit", main_sign, 1);
    // aux
    wr(8'h25, 8'hDF); wr(8'h26, 8'hFF);
    chk("R3 aux_m commit", aux_m, 13'h1FFF);
    chk("R6 filter code", aux_if_flt, 2'b10);
    chk("R4 aux enable", aux_en, 1);
    wr(8'h27, 8'hBF); wr(8'h28, 8'h01);
    chk("R3 aux_n commit", aux_n, 14'h3F01);
    chk("R6 if div2", aux_if_div2, 1);
    // unmapped
    wr(8'h1F, 8'h00); wr(8'h29, 8'h00); wr(8'h00, 8'h00); wr(8'hFF, 8'h00);
    chk("R9 main_m untouched", main_m, 14'h0123);
    chk("R9 aux_n untouched", aux_n, 14'h3F01);
    chk("R9 enables untouched", {aux_en, main_en}, 2'b11);
    // lock timing and interrupt
    irq_mask = 2'b01;
    lock_det_main = 1;
    step(1);
    chk("R7 lock after one edge", main_lock, 0);
    step(1);
    chk("R7 lock after two edges", main_lock, 1);
    chk("R8 irq not yet", irq, 0);
    step(1);
    chk("R8 irq raised", irq, 1);
    step(4);
    chk("R8 irq held", irq, 1);
    stat_rd = 1; step(1); stat_rd = 0;
    chk("R8 irq cleared by read", irq, 0);
    // immediate disable
    wr(8'h20, 8'h41);
    chk("R5 main disabled", main_en, 0);
    chk("R7 lock gated off", main_lock, 0);
    chk("R5 main_m kept", main_m, 14'h0123);
    step(1);
    chk("R8 irq on lock loss", irq, 1);
    stat_rd = 1; step(1); stat_rd = 0;
    // re-enable needs commit
    wr(8'h20, 8'h80);
    chk("R4 top byte alone stays off", main_en, 0);
    step(2);
    chk("R4 still off", main_en, 0);
    wr(8'h21, 8'h10);
    chk("R4 enabled by commit", main_en, 1);
    chk("R3 new ratio", main_m, 14'h0010);
    step(3);
    stat_rd = 1; step(1); stat_rd = 0;
    // aux lock with mask off
    irq_mask = 2'b00;
    lock_det_aux = 1;
    step(3);
    chk("R7 aux lock", aux_lock, 1);
    chk("R8 masked no irq", irq, 0);
    // read coinciding with masked change
    irq_mask = 2'b10;
    wr(8'h25, 8'h00);
    chk("R5 aux disabled", aux_en, 0);
    stat_rd = 1; step(1); stat_rd = 0;
    chk("R8 set wins over read", irq, 1);
    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      irq_mask = 2'($urandom);
      stat_rd = ($urandom % 5) == 0;
      if ($urandom % 3 == 0) lock_det_main = $urandom;
      if ($urandom % 3 == 0) lock_det_aux = $urandom;
      host_valid = $urandom;
      host_addr = 8'h1E + 8'($urandom % 12);
      host_data = $urandom;
      step(1);
    end
    host_valid = 0; stat_rd = 0;
    step(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule